// File: doc/BRIEF.md
# Interrupt Priority Arbiter and Acknowledge Unit

This block sits in front of one processor core and decides which interrupt that core sees next. Each clock it scans a vector of candidate sources. Every source carries its own identifier, an 8-bit priority, a group code and an enable bit. The unit picks the most urgent eligible source and raises a request line when that source passes two tests: it must be more urgent than the core's priority mask, and more urgent than the priority the core is already running at.

Software running on the core reads an acknowledge strobe and gets back either the winning identifier or a reserved code. The unit keeps a small stack of running priorities so that handlers can nest. End-of-interrupt writes pop that stack. A separate deactivate pulse tells the per-source state storage that an interrupt is finished, either together with the end-of-interrupt write or on its own write, depending on the completion mode.

The storage of pending and active state for each source lives outside this block. That outer logic clears a source's pending input after it sees an acknowledge that returned that source's identifier.

Top module: `irq_prio_cpuif`

## Requirements
- R1: After reset, `irq_req` is low, `run_prio` is 0xFF, and neither `ack_vld` nor `deact_vld` pulses.
- R2: The winner is the pending, enabled candidate with the numerically lowest priority. Only the upper `PRIO_BITS` bits of each priority and of the mask are kept; the lower bits count as zero. When truncated priorities are equal, the lowest identifier wins.
- R3: A request is signalled, and an acknowledge succeeds, only when the winner's truncated priority is strictly below the truncated priority mask.
- R4: While the stack holds at least one entry, the winner must also have a group field strictly below the running priority's group field. The group field is the priority ANDed with 0xFF shifted left by `bin_point`. With an empty stack, this test passes.
- R5: A source is a candidate only if three things hold: its enable bit is set, and its group's bit is set in both `glb_grp_en` and `cpu_grp_en`. In the enable vectors, bit 0 is group 0, bit 1 is secure group 1 and bit 2 is non-secure group 1. In the group codes, 0 is group 0, 1 is secure group 1, 2 is non-secure group 1, and 3 is never a candidate.
- R6: A group-1 acknowledge (`ack_rd` with `ack_g0`=0) reports its result on `ack_vld`/`ack_id` one cycle after the strobe. The result is the winner's identifier when a request is signalled and the winner is in group code 1 or 2; otherwise it is 1023. A successful acknowledge pushes the winner's truncated priority, which then appears on `run_prio`.
- R7: A group-0 acknowledge returns the identifier of a signalled group-0 winner. If the signalled winner is in group 1, the result is 1020 (secure) or 1021 (non-secure) when `at_top_el` is 1, and 1023 when `at_top_el` is 0. With no signalled winner, the result is 1023.
- R8: An acknowledge that returns 1020, 1021 or 1023 leaves `run_prio` unchanged.
- R9: With `eoi_mode`=0, an end-of-interrupt write pops the stack. One cycle later it pulses `deact_vld` with the identifier of the entry that was popped.
- R10: With `eoi_mode`=1, an end-of-interrupt write only pops the stack and produces no deactivate pulse. A `deact_wr` strobe then pulses `deact_vld` with `deact_id_in`. With `eoi_mode`=0, `deact_wr` is ignored.
- R11: While the stack holds `STACK_DEPTH` entries, `irq_req` stays low and every acknowledge returns 1023.
- R12: An end-of-interrupt write with an empty stack is ignored: there is no deactivate pulse and `run_prio` stays 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend | input | NUM_SRC | Pending flag per source |
| src_en | input | NUM_SRC | Enable flag per source |
| src_grp | input | 2*NUM_SRC | Group code per source |
| src_prio | input | 8*NUM_SRC | Priority per source |
| src_id | input | 10*NUM_SRC | Identifier per source |
| glb_grp_en | input | 3 | System-wide group enables |
| cpu_grp_en | input | 3 | Core-level group enables |
| prio_mask | input | 8 | Priority mask of the core |
| bin_point | input | 3 | Split between group field and sub-priority |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_g0 | input | 1 | 1 selects the group-0 acknowledge |
| at_top_el | input | 1 | Core is at its highest privilege level |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_mode | input | 1 | 0 means the EOI write also deactivates; 1 means it only drops priority |
| deact_wr | input | 1 | Separate deactivate write strobe |
| deact_id_in | input | 10 | Identifier carried by the deactivate write |
| irq_req | output | 1 | Interrupt request to the core |
| ack_vld | output | 1 | Acknowledge result valid, one cycle |
| ack_id | output | 10 | Acknowledge result |
| deact_vld | output | 1 | Deactivate pulse to the state storage |
| deact_id | output | 10 | Identifier being deactivated |
| run_prio | output | 8 | Current running priority |

## Verification
The assertions assume that at most one of `ack_rd`, `eoi_wr` and `deact_wr` is high in any cycle. They also assume that `eoi_mode` and the mask do not change in the cycle of a strobe. The stimulus issues every strobe on its own, in a one-cycle window, and changes mask, binary point and mode only while all strobes are low. After each successful acknowledge, the stimulus clears the matching pending input, as the outer state storage would.

// File: rtl/irq_cpuif_pkg.sv
package irq_cpuif_pkg;
    localparam int PW = 8;
    localparam int IW = 10;

    typedef enum logic [1:0] {
        GRP0   = 2'd0,
        GRP1S  = 2'd1,
        GRP1NS = 2'd2,
        GRPX   = 2'd3
    } grp_e;

    localparam logic [IW-1:0] ID_SPURIOUS = 10'd1023;
    localparam logic [IW-1:0] ID_OTHER_S  = 10'd1020;
    localparam logic [IW-1:0] ID_OTHER_NS = 10'd1021;
    localparam logic [PW-1:0] PRIO_IDLE   = 8'hFF;

    // group field selected by the binary point
    function automatic logic [PW-1:0] grp_field(input logic [PW-1:0] p, input logic [2:0] bp);
        return p & (8'hFF << bp);
    endfunction
endpackage

// File: rtl/irq_best_sel.sv
module irq_best_sel
    import irq_cpuif_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int PRIO_BITS = 5
) (
    input  logic [NUM_SRC-1:0]    pend,
    input  logic [NUM_SRC-1:0]    en,
    input  logic [2*NUM_SRC-1:0]  grp,
    input  logic [PW*NUM_SRC-1:0] prio,
    input  logic [IW*NUM_SRC-1:0] id,
    input  logic [2:0]            glb_en,
    input  logic [2:0]            cpu_en,
    output logic                  found,
    output logic [PW-1:0]         best_prio,
    output logic [IW-1:0]         best_id,
    output logic [1:0]            best_grp
);
    localparam logic [PW-1:0] PMASK = 8'hFF << (PW - PRIO_BITS);

    logic [NUM_SRC-1:0] elig;
    logic [PW-1:0]      p_t  [NUM_SRC];
    logic [IW-1:0]      id_s [NUM_SRC];
    logic [1:0]         g_s  [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign g_s[i]  = grp[2*i +: 2];
        assign p_t[i]  = prio[PW*i +: PW] & PMASK;
        assign id_s[i] = id[IW*i +: IW];
        assign elig[i] = pend[i] && en[i] && (g_s[i] != GRPX)
                         && glb_en[g_s[i]] && cpu_en[g_s[i]];
    end

    always_comb begin
        found     = 1'b0;
        best_prio = PRIO_IDLE;
        best_id   = ID_SPURIOUS;
        best_grp  = GRPX;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!found || (p_t[i] < best_prio)
                            || ((p_t[i] == best_prio) && (id_s[i] < best_id)))) begin
                found     = 1'b1;
                best_prio = p_t[i];
                best_id   = id_s[i];
                best_grp  = g_s[i];
            end
        end
    end
endmodule

// File: rtl/irq_run_stack.sv
module irq_run_stack
    import irq_cpuif_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_prio,
    input  logic [IW-1:0] push_id,
    input  logic          pop,
    output logic [PW-1:0] top_prio,
    output logic [IW-1:0] top_id,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] prio;
        logic [DEPTH-1:0][IW-1:0] id;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    assign empty = (stk_q.cnt == '0);
    assign full  = (int'(stk_q.cnt) == DEPTH);

    always_comb begin
        top_prio = PRIO_IDLE;
        top_id   = ID_SPURIOUS;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(stk_q.cnt) == i + 1) begin
                top_prio = stk_q.prio[i];
                top_id   = stk_q.id[i];
            end
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(stk_q.cnt) == i) begin
                    stk_d.prio[i] = push_prio;
                    stk_d.id[i]   = push_id;
                end
            end
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end
endmodule

// File: rtl/irq_prio_cpuif.sv
module irq_prio_cpuif
    import irq_cpuif_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int PRIO_BITS   = 5,
    parameter int STACK_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_pend,
    input  logic [NUM_SRC-1:0]    src_en,
    input  logic [2*NUM_SRC-1:0]  src_grp,
    input  logic [8*NUM_SRC-1:0]  src_prio,
    input  logic [10*NUM_SRC-1:0] src_id,
    input  logic [2:0]            glb_grp_en,
    input  logic [2:0]            cpu_grp_en,
    input  logic [7:0]            prio_mask,
    input  logic [2:0]            bin_point,
    input  logic                  ack_rd,
    input  logic                  ack_g0,
    input  logic                  at_top_el,
    input  logic                  eoi_wr,
    input  logic                  eoi_mode,
    input  logic                  deact_wr,
    input  logic [9:0]            deact_id_in,
    output logic                  irq_req,
    output logic                  ack_vld,
    output logic [9:0]            ack_id,
    output logic                  deact_vld,
    output logic [9:0]            deact_id,
    output logic [7:0]            run_prio
);
    localparam logic [PW-1:0] PMASK = 8'hFF << (PW - PRIO_BITS);

    typedef struct packed {
        logic          ack_vld;
        logic [IW-1:0] ack_id;
        logic          deact_vld;
        logic [IW-1:0] deact_id;
    } out_t;

    out_t o_d, o_q;

    logic          found;
    logic [PW-1:0] best_prio;
    logic [IW-1:0] best_id;
    logic [1:0]    best_grp;
    logic [PW-1:0] top_prio;
    logic [IW-1:0] top_id;
    logic          stk_empty, stk_full;
    logic          pass_mask, pass_pre, signal;
    logic          take, pop;
    logic [IW-1:0] ack_res;

    irq_best_sel #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) u_sel (
        .pend(src_pend), .en(src_en), .grp(src_grp), .prio(src_prio), .id(src_id),
        .glb_en(glb_grp_en), .cpu_en(cpu_grp_en),
        .found(found), .best_prio(best_prio), .best_id(best_id), .best_grp(best_grp)
    );

    irq_run_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push(take), .push_prio(best_prio), .push_id(best_id), .pop(pop),
        .top_prio(top_prio), .top_id(top_id), .empty(stk_empty), .full(stk_full)
    );

    assign pass_mask = best_prio < (prio_mask & PMASK);
    assign pass_pre  = stk_empty ||
                       (grp_field(best_prio, bin_point) < grp_field(top_prio, bin_point));
    assign signal    = found && pass_mask && pass_pre && !stk_full;
    assign pop       = eoi_wr && !ack_rd;

    always_comb begin
        ack_res = ID_SPURIOUS;
        take    = 1'b0;
        if (signal) begin
            if (ack_g0) begin
                if (best_grp == GRP0) begin
                    ack_res = best_id;
                    take    = ack_rd;
                end else if (at_top_el) begin
                    ack_res = (best_grp == GRP1S) ? ID_OTHER_S : ID_OTHER_NS;
                end
            end else if (best_grp == GRP1S || best_grp == GRP1NS) begin
                ack_res = best_id;
                take    = ack_rd;
            end
        end
    end

    always_comb begin
        o_d           = o_q;
        o_d.ack_vld   = ack_rd;
        o_d.deact_vld = 1'b0;
        if (ack_rd) o_d.ack_id = ack_res;
        if (pop && !stk_empty && !eoi_mode) begin
            o_d.deact_vld = 1'b1;
            o_d.deact_id  = top_id;
        end else if (deact_wr && eoi_mode && !ack_rd && !eoi_wr) begin
            o_d.deact_vld = 1'b1;
            o_d.deact_id  = deact_id_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{ack_vld: 1'b0, ack_id: ID_SPURIOUS, deact_vld: 1'b0, deact_id: '0};
        else        o_q <= o_d;
    end

    assign irq_req   = signal;
    assign ack_vld   = o_q.ack_vld;
    assign ack_id    = o_q.ack_id;
    assign deact_vld = o_q.deact_vld;
    assign deact_id  = o_q.deact_id;
    assign run_prio  = top_prio;
endmodule

// File: rtl/irq_cpuif_chk.sv
module irq_cpuif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_rd,
    input logic       eoi_wr,
    input logic       eoi_mode,
    input logic       deact_wr,
    input logic [7:0] prio_mask,
    input logic       irq_req,
    input logic       ack_vld,
    input logic [9:0] ack_id,
    input logic       deact_vld,
    input logic [7:0] run_prio,
    input logic       stk_full
);
    // R3: an accepted interrupt ran below the mask present at the strobe
    a_r3_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_id < 10'd1020) |-> (run_prio < $past(prio_mask)));

    // R4: an accepted interrupt always runs more urgently than before
    a_r4_push_deeper: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_id < 10'd1020) |-> (run_prio < $past(run_prio)));

    // R8: a reserved code leaves the running priority alone
    a_r8_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_id >= 10'd1020) |-> $stable(run_prio));

    // R9: mode 0 completion on a busy core deactivates
    a_r9_eoi_deact: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_rd && !eoi_mode && run_prio != 8'hFF) |=> deact_vld);

    // R10: mode 1 without a deactivate write never deactivates
    a_r10_split_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_mode && !deact_wr) |=> !deact_vld);

    // R11: a full stack blocks the request line
    a_r11_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !irq_req);
endmodule

bind irq_prio_cpuif irq_cpuif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_mode(eoi_mode),
    .deact_wr(deact_wr), .prio_mask(prio_mask), .irq_req(irq_req), .ack_vld(ack_vld),
    .ack_id(ack_id), .deact_vld(deact_vld), .run_prio(run_prio), .stk_full(stk_full)
);

// File: tb/sim_irq_prio_cpuif.sv
module sim_irq_prio_cpuif;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]    pend = '0, en = '0;
    logic [1:0]      grp  [N];
    logic [7:0]      prio [N];
    logic [2*N-1:0]  grp_f;
    logic [8*N-1:0]  prio_f;
    logic [10*N-1:0] id_f;
    logic [2:0] glb_en = 3'b111, cpu_en = 3'b111;
    logic [7:0] mask = 8'hFF;
    logic [2:0] bp = 3'd0;
    logic ack_rd = 0, ack_g0 = 0, top_el = 0, eoi_wr = 0, eoi_mode = 0, deact_wr = 0;
    logic [9:0] deact_in = '0;
    logic irq_req, ack_vld, deact_vld;
    logic [9:0] ack_id, deact_id;
    logic [7:0] run_prio;

    function automatic logic [9:0] sid(input int i);
        return 10'(100 - 7 * i);
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) begin
            grp_f[2*i +: 2]   = grp[i];
            prio_f[8*i +: 8]  = prio[i];
            id_f[10*i +: 10]  = sid(i);
        end
    end

    irq_prio_cpuif #(.NUM_SRC(N), .PRIO_BITS(5), .STACK_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_en(en), .src_grp(grp_f),
        .src_prio(prio_f), .src_id(id_f), .glb_grp_en(glb_en), .cpu_grp_en(cpu_en),
        .prio_mask(mask), .bin_point(bp), .ack_rd(ack_rd), .ack_g0(ack_g0),
        .at_top_el(top_el), .eoi_wr(eoi_wr), .eoi_mode(eoi_mode), .deact_wr(deact_wr),
        .deact_id_in(deact_in), .irq_req(irq_req), .ack_vld(ack_vld), .ack_id(ack_id),
        .deact_vld(deact_vld), .deact_id(deact_id), .run_prio(run_prio)
    );

    int checks = 0, errors = 0;
    logic [9:0] ack_q[$];
    logic [9:0] dea_q[$];
    string ack_tag[$];
    string dea_tag[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares produced results against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && ack_vld) begin
            if (ack_q.size() == 0) check("ack unexpected", 1, 0);
            else check(ack_tag.pop_front(), ack_id, ack_q.pop_front());
        end
        if (rst_n && deact_vld) begin
            if (dea_q.size() == 0) check("R10/R12 unexpected deactivate", {22'd0, deact_id}, 32'hFFFF);
            else check(dea_tag.pop_front(), deact_id, dea_q.pop_front());
        end
    end

    task automatic src(input int i, input logic p, input logic e, input logic [1:0] g, input logic [7:0] pr);
        pend[i] = p; en[i] = e; grp[i] = g; prio[i] = pr;
    endtask

    task automatic ack(input string tag, input logic g0, input logic [9:0] exp);
        @(negedge clk);
        ack_g0 = g0; ack_rd = 1'b1;
        ack_q.push_back(exp); ack_tag.push_back(tag);
        @(negedge clk);
        ack_rd = 1'b0;
    endtask

    task automatic eoi(input string tag, input logic mode, input logic exp_d, input logic [9:0] id);
        @(negedge clk);
        eoi_mode = mode; eoi_wr = 1'b1;
        if (exp_d) begin dea_q.push_back(id); dea_tag.push_back(tag); end
        @(negedge clk);
        eoi_wr = 1'b0;
    endtask

    task automatic dwr(input string tag, input logic exp_d, input logic [9:0] id);
        @(negedge clk);
        deact_in = id; deact_wr = 1'b1;
        if (exp_d) begin dea_q.push_back(id); dea_tag.push_back(tag); end
        @(negedge clk);
        deact_wr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) begin grp[i] = 2'd2; prio[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check("R1 irq_req", irq_req, 0);
        check("R1 run_prio", run_prio, 8'hFF);
        check("R1 ack_vld", ack_vld, 0);
        check("R1 deact_vld", deact_vld, 0);

        // R2 selection by full priority
        src(2, 1, 1, 2'd2, 8'h40);
        src(5, 1, 1, 2'd2, 8'h30);
        settle();
        check("R3 request raised", irq_req, 1);
        ack("R2 most urgent id", 0, sid(5));
        pend[5] = 0;
        settle();
        check("R6 run_prio pushed", run_prio, 8'h30);
        check("R4 no preempt by less urgent", irq_req, 0);
        eoi("R9 deact after eoi", 0, 1, sid(5));
        settle();
        check("R9 run_prio popped", run_prio, 8'hFF);
        check("R3 pending returns", irq_req, 1);
        ack("R6 second id", 0, sid(2));
        pend[2] = 0;
        eoi("R9 deact second", 0, 1, sid(2));

        // R2 truncated tie goes to lowest id
        src(1, 1, 1, 2'd2, 8'h44);
        src(6, 1, 1, 2'd2, 8'h41);
        ack("R2 tie lowest id", 0, sid(6));
        pend[6] = 0; pend[1] = 0;
        settle();
        check("R2 truncated run_prio", run_prio, 8'h40);
        eoi("R9 deact tie", 0, 1, sid(6));

        // R3 mask strictness
        src(0, 1, 1, 2'd2, 8'h50);
        mask = 8'h50;
        settle();
        check("R3 equal to mask blocked", irq_req, 0);
        ack("R6 spurious under mask", 0, 10'd1023);
        settle();
        check("R8 run_prio after spurious", run_prio, 8'hFF);
        mask = 8'h53;
        settle();
        check("R2 mask truncated", irq_req, 0);
        mask = 8'h58;
        settle();
        check("R3 above mask passes", irq_req, 1);
        mask = 8'hFF;
        ack("R6 ack src0", 0, sid(0));
        pend[0] = 0;

        // R4 binary point
        src(3, 1, 1, 2'd2, 8'h48);
        bp = 3'd5;
        settle();
        check("R4 same group no preempt", irq_req, 0);
        bp = 3'd3;
        settle();
        check("R4 finer group preempts", irq_req, 1);
        ack("R4 nested ack", 0, sid(3));
        pend[3] = 0;
        settle();
        check("R4 nested run_prio", run_prio, 8'h48);
        bp = 3'd0;
        eoi("R10 mode1 eoi", 1, 0, 0);
        settle();
        check("R10 priority dropped", run_prio, 8'h50);
        dwr("R10 separate deact", 1, sid(3));
        eoi("R10 mode1 eoi outer", 1, 0, 0);
        eoi_mode = 0;
        dwr("R10 ignored in mode0", 0, sid(0));
        settle();
        check("R10 run_prio idle", run_prio, 8'hFF);

        // R5 enables
        src(4, 1, 0, 2'd0, 8'h10);
        settle();
        check("R5 source disabled", irq_req, 0);
        en[4] = 1; glb_en = 3'b110;
        settle();
        check("R5 global group off", irq_req, 0);
        glb_en = 3'b111; cpu_en = 3'b110;
        settle();
        check("R5 core group off", irq_req, 0);
        cpu_en = 3'b111;
        settle();
        check("R5 all enabled", irq_req, 1);

        // R7 group-0 acknowledge
        ack("R6 wrong group spurious", 0, 10'd1023);
        ack("R7 group0 id", 1, sid(4));
        pend[4] = 0;
        settle();
        check("R7 run_prio", run_prio, 8'h10);
        eoi("R9 deact g0", 0, 1, sid(4));
        src(7, 1, 1, 2'd1, 8'h20);
        top_el = 1;
        ack("R7 secure g1 code", 1, 10'd1020);
        settle();
        check("R8 run after 1020", run_prio, 8'hFF);
        grp[7] = 2'd2;
        ack("R7 nonsecure g1 code", 1, 10'd1021);
        top_el = 0;
        ack("R7 not top spurious", 1, 10'd1023);
        ack("R6 g1 id", 0, sid(7));
        pend[7] = 0;
        eoi("R9 deact g1", 0, 1, sid(7));

        // R11 overflow
        src(0, 1, 1, 2'd2, 8'h70); ack("R11 fill 1", 0, sid(0)); pend[0] = 0;
        src(1, 1, 1, 2'd2, 8'h60); ack("R11 fill 2", 0, sid(1)); pend[1] = 0;
        src(2, 1, 1, 2'd2, 8'h50); ack("R11 fill 3", 0, sid(2)); pend[2] = 0;
        src(3, 1, 1, 2'd2, 8'h40); ack("R11 fill 4", 0, sid(3)); pend[3] = 0;
        src(4, 1, 1, 2'd0, 8'h08);
        settle();
        check("R11 full run_prio", run_prio, 8'h40);
        check("R11 full no request", irq_req, 0);
        ack("R11 full spurious", 1, 10'd1023);
        eoi("R11 pop 4", 0, 1, sid(3));
        settle();
        check("R11 room again", irq_req, 1);
        pend[4] = 0;
        eoi("R9 pop 3", 0, 1, sid(2));
        eoi("R9 pop 2", 0, 1, sid(1));
        eoi("R9 pop 1", 0, 1, sid(0));
        eoi("R12 empty eoi", 0, 0, 0);
        settle();
        check("R12 run_prio idle", run_prio, 8'hFF);
        check("scoreboard ack drained", ack_q.size(), 0);
        check("scoreboard deact drained", dea_q.size(), 0);
        summary();
    end
endmodule